// File: doc/BRIEF.md
# Sixteen-Pin Output and Input Port

This block is a general-purpose pin port. It connects to a simple 32-bit memory-mapped bus. A latch register drives sixteen output pins. Sixteen input pins are resynchronised and then captured into a read-only sample register.

Software can move single output pins without a read-modify-write sequence, through two write-only command registers:
- The atomic command word sets pins with its low half and clears pins with its high half.
- The clear-only word drops pins named in its low half.

Two mode words and a guard word are decoded and kept as plain 32-bit storage. They have no effect on the pins.

A bus request is presented for one cycle with `busValid`. The request takes effect at that clock edge. `busReady` pulses high in the following cycle, and read data is valid while `busReady` is high. Bit 0 of the data word is the least significant bit of the lowest-addressed byte, and it maps to pin 0.

Top module: `gpio_port`

## Requirements
- R1: After reset `pinOut` is 0x0000, and the words at offsets 0x00, 0x04, 0x0C and 0x18 all read 0x00000000.
- R2: A write to offset 0x0C loads data bits 15..0 into the output latch, and `pinOut[y]` follows bit y from the next cycle. Bits 31..16 of the write are dropped, and a read of 0x0C returns the latch with bits 31..16 zero. Without a bus write, `pinOut` does not change.
- R3: A write to offset 0x10 with bit y (0..15) at 1 drives output bit y to 1.
- R4: A write to offset 0x10 with bit 16+y at 1 drives output bit y to 0. Zero bits in either half leave the pin as it was.
- R5: When one write to 0x10 has both bit y and bit 16+y at 1, output bit y ends at 1.
- R6: A write to offset 0x14 with bit y (0..15) at 1 drives output bit y to 0. Bits 31..16 of that write have no effect.
- R7: Reads of offsets 0x10 and 0x14 return 0x00000000.
- R8: Offset 0x08 reads the input pins in bits 15..0, with bits 31..16 zero. A pin change becomes visible after two synchronizer flops and one capture flop. Writes to 0x08 change nothing.
- R9: Offsets 0x00, 0x04 and 0x18 store all 32 written bits and read them back unchanged, without affecting `pinOut`.
- R10: A write to an undecoded offset (0x1C and above, or a byte address not a multiple of four) changes no register or pin. A read from such an offset returns 0x00000000.
- R11: `busReady` is high for exactly the one cycle after each cycle in which `busValid` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Request strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset from the port base |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busReady is high |
| busReady | output | 1 | Completion pulse |
| pinIn | input | PINS | Asynchronous input pins |
| pinOut | output | PINS | Output pin levels |

## Verification
A wrong output latch is visible on `pinOut` in the cycle after the write that causes it. A read of 0x0C shows the same error one cycle after the read request.

Because every command register acts on the latch's previous contents, one mistaken set, clear or priority decision carries into every later pin check until the next full write.

A mistake in the input path shows as a sample arriving one edge early or late, which the bench can see when it reads back immediately after a pin change. Stray decoding shows up as a non-zero read from a write-only or undecoded offset, or as a pin that moves after a write that should have no effect.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int DATA_W = 32;
  localparam int HALF_W = 16;

  // word index = byte offset / 4
  localparam int IDX_CFG_LO = 0;
  localparam int IDX_CFG_HI = 1;
  localparam int IDX_IN     = 2;
  localparam int IDX_OUT    = 3;
  localparam int IDX_SETCLR = 4;
  localparam int IDX_CLR    = 5;
  localparam int IDX_GUARD  = 6;

  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_CFG_LO = 3'd1,
    SEL_CFG_HI = 3'd2,
    SEL_IN     = 3'd3,
    SEL_OUT    = 3'd4,
    SEL_GUARD  = 3'd5
  } rdSel_e;

  typedef struct packed {
    logic   wrCfgLo;
    logic   wrCfgHi;
    logic   wrOut;
    logic   wrSetClr;
    logic   wrClr;
    logic   wrGuard;
    logic   rdEn;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobe,
  output logic              busReady
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             doWr;
  logic             doRd;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign doWr    = busValid && busWrite && aligned;
  assign doRd    = busValid && !busWrite;

  always_comb begin
    strobe.wrCfgLo  = 1'b0;
    strobe.wrCfgHi  = 1'b0;
    strobe.wrOut    = 1'b0;
    strobe.wrSetClr = 1'b0;
    strobe.wrClr    = 1'b0;
    strobe.wrGuard  = 1'b0;
    strobe.rdEn     = doRd;
    strobe.rdSel    = SEL_NONE;
    if (aligned) begin
      if (wordIdx == IDX_W'(IDX_CFG_LO)) begin
        strobe.wrCfgLo = doWr;
        strobe.rdSel   = SEL_CFG_LO;
      end else if (wordIdx == IDX_W'(IDX_CFG_HI)) begin
        strobe.wrCfgHi = doWr;
        strobe.rdSel   = SEL_CFG_HI;
      end else if (wordIdx == IDX_W'(IDX_IN)) begin
        strobe.rdSel   = SEL_IN;
      end else if (wordIdx == IDX_W'(IDX_OUT)) begin
        strobe.wrOut   = doWr;
        strobe.rdSel   = SEL_OUT;
      end else if (wordIdx == IDX_W'(IDX_SETCLR)) begin
        strobe.wrSetClr = doWr;
      end else if (wordIdx == IDX_W'(IDX_CLR)) begin
        strobe.wrClr   = doWr;
      end else if (wordIdx == IDX_W'(IDX_GUARD)) begin
        strobe.wrGuard = doWr;
        strobe.rdSel   = SEL_GUARD;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busReady <= 1'b0;
    else       busReady <= busValid;
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int PINS        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [DATA_W-1:0] busRdata
);

  localparam int PAD_W = DATA_W - PINS;

  logic [DATA_W-1:0] cfgLo, cfgHi, guardReg;
  logic [PINS-1:0]   outReg, outNext, inReg;
  logic [PINS-1:0]   setMask, clrMask;
  logic [PINS-1:0]   syncStage [SYNC_STAGES];
  logic [DATA_W-1:0] rdMux;

  // input resynchronizer chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncStage[0] <= '0;
          else       syncStage[0] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncStage[s] <= '0;
          else       syncStage[s] <= syncStage[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inReg <= '0;
    else       inReg <= syncStage[SYNC_STAGES-1];
  end

  // output latch update; set is applied after clear so set wins
  assign setMask = busWdata[PINS-1:0];
  assign clrMask = busWdata[HALF_W +: PINS];

  always_comb begin
    outNext = outReg;
    if (strobe.wrOut)    outNext = busWdata[PINS-1:0];
    if (strobe.wrSetClr) outNext = (outReg & ~clrMask) | setMask;
    if (strobe.wrClr)    outNext = outReg & ~setMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else       outReg <= outNext;
  end

  assign pinOut = outReg;

  // plain storage words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLo    <= '0;
      cfgHi    <= '0;
      guardReg <= '0;
    end else begin
      if (strobe.wrCfgLo) cfgLo    <= busWdata;
      if (strobe.wrCfgHi) cfgHi    <= busWdata;
      if (strobe.wrGuard) guardReg <= busWdata;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_CFG_LO: rdMux = cfgLo;
      SEL_CFG_HI: rdMux = cfgHi;
      SEL_IN:     rdMux = {{PAD_W{1'b0}}, inReg};
      SEL_OUT:    rdMux = {{PAD_W{1'b0}}, outReg};
      SEL_GUARD:  rdMux = guardReg;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            busRdata <= '0;
    else if (strobe.rdEn) busRdata <= rdMux;
    else                  busRdata <= '0;
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PINS        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busReady,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut
);

  strobe_t strobe;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe),
    .busReady (busReady)
  );

  gpio_port_dp #(.PINS(PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .busRdata (busRdata)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int ADDR_W = 8,
  parameter int PINS   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              busReady,
  input logic [PINS-1:0]   pinIn,
  input logic [PINS-1:0]   pinOut
);

  logic [ADDR_W-1:0] off;
  logic              wrAny, wrSc, wrClr, rdWo, rdOut, rdUndec;

  assign off     = busAddr;
  assign wrAny   = busValid && busWrite;
  assign wrSc    = wrAny && (off == ADDR_W'(8'h10));
  assign wrClr   = wrAny && (off == ADDR_W'(8'h14));
  assign rdWo    = busValid && !busWrite && (off == ADDR_W'(8'h10) || off == ADDR_W'(8'h14));
  assign rdOut   = busValid && !busWrite && (off == ADDR_W'(8'h0C));
  assign rdUndec = busValid && !busWrite && (off >= ADDR_W'(8'h1C) || off[1:0] != 2'b00);

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> busReady);
  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !busReady);
  p_pins_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrAny |=> $stable(pinOut));
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdOut |=> busRdata[31:16] == 16'h0);
  p_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrSc |=> ((pinOut & $past(busWdata[PINS-1:0])) == $past(busWdata[PINS-1:0])));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrSc |=> ((pinOut & $past(busWdata[16 +: PINS]) & ~$past(busWdata[PINS-1:0])) == '0));
  p_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrSc |=> (((pinOut ^ $past(pinOut)) & ~$past(busWdata[PINS-1:0]) & ~$past(busWdata[16 +: PINS])) == '0));
  p_bitclr_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrClr |=> pinOut == ($past(pinOut) & ~$past(busWdata[PINS-1:0])));
  p_wo_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdWo |=> busRdata == 32'h0);
  p_undec_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdUndec |=> busRdata == 32'h0);

endmodule

bind gpio_port gpio_port_chk #(.ADDR_W(ADDR_W), .PINS(PINS)) u_chk (.*);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int PINS = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busValid = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              busReady;
  logic [PINS-1:0]   pinIn = '0;
  logic [PINS-1:0]   pinOut;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  bit          isRdQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port #(.ADDR_W(ADDR_W), .PINS(PINS)) u_dut (.*);

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    expQ.push_back('0); isRdQ.push_back(1'b0); tagQ.push_back("R11");
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    expQ.push_back(e); isRdQ.push_back(1'b1); tagQ.push_back(tag);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic checkPins(input logic [PINS-1:0] e, input string tag);
    testCount++;
    if (pinOut !== e) begin
      failCount++;
      $display("FAIL %s pinOut actual=%h expected=%h", tag, pinOut, e);
    end
  endtask

  task automatic checkIdle();
    @(negedge clk);
    testCount++;
    if (busReady !== 1'b0) begin
      failCount++;
      $display("FAIL R11 busReady actual=%b expected=0", busReady);
    end
  endtask

  // monitor: pops one expected item per completion pulse
  always @(negedge clk) begin
    if (rstN && busReady) begin
      testCount++;
      if (expQ.size() == 0) begin
        failCount++;
        $display("FAIL R11 busReady actual=1 expected=0 (no request)");
      end else begin
        logic [31:0] e;
        bit rd;
        string t;
        e = expQ.pop_front(); rd = isRdQ.pop_front(); t = tagQ.pop_front();
        if (rd && busRdata !== e) begin
          failCount++;
          $display("FAIL %s busRdata actual=%h expected=%h", t, busRdata, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkPins(16'h0000, "R1");
    doRead(8'h00, 32'h0, "R1");
    doRead(8'h04, 32'h0, "R1");
    doRead(8'h0C, 32'h0, "R1");
    doRead(8'h18, 32'h0, "R1");
    // R2 output latch write
    doWrite(8'h0C, 32'hABCD1234);
    checkPins(16'h1234, "R2");
    doRead(8'h0C, 32'h00001234, "R2");
    checkIdle(); // R11
    // R3 set half
    doWrite(8'h10, 32'h00008001);
    checkPins(16'h9235, "R3");
    // R4 clear half, zero word
    doWrite(8'h10, 32'h00300000);
    checkPins(16'h9205, "R4");
    doWrite(8'h10, 32'h00000000);
    checkPins(16'h9205, "R4");
    // R5 set wins
    doWrite(8'h10, 32'h00400040);
    checkPins(16'h9245, "R5");
    doWrite(8'h10, 32'h80008000);
    checkPins(16'h9245, "R5");
    // R6 clear-only word
    doWrite(8'h14, 32'hFFFF0004);
    checkPins(16'h9241, "R6");
    doWrite(8'h14, 32'hFFFF0000);
    checkPins(16'h9241, "R6");
    doRead(8'h0C, 32'h00009241, "R6");
    // R7 write-only offsets read zero
    doRead(8'h10, 32'h0, "R7");
    doRead(8'h14, 32'h0, "R7");
    // R8 input sampling
    @(negedge clk); pinIn = 16'hA5C3;
    repeat (4) @(negedge clk);
    doRead(8'h08, 32'h0000A5C3, "R8");
    doWrite(8'h08, 32'hFFFFFFFF);
    checkPins(16'h9241, "R8");
    doRead(8'h08, 32'h0000A5C3, "R8");
    @(negedge clk); pinIn = 16'h0F0F;
    doRead(8'h08, 32'h0000A5C3, "R8");
    repeat (3) @(negedge clk);
    doRead(8'h08, 32'h00000F0F, "R8");
    // R9 storage words
    doWrite(8'h00, 32'hDEADBEEF);
    doWrite(8'h04, 32'h12345678);
    doWrite(8'h18, 32'h000100FF);
    checkPins(16'h9241, "R9");
    doRead(8'h00, 32'hDEADBEEF, "R9");
    doRead(8'h04, 32'h12345678, "R9");
    doRead(8'h18, 32'h000100FF, "R9");
    // R10 undecoded offsets
    doWrite(8'h1C, 32'hFFFFFFFF);
    checkPins(16'h9241, "R10");
    doWrite(8'h0D, 32'h00000000);
    checkPins(16'h9241, "R10");
    doWrite(8'h01, 32'h00000000);
    doRead(8'h00, 32'hDEADBEEF, "R10");
    doRead(8'h1C, 32'h0, "R10");
    doRead(8'h40, 32'h0, "R10");
    doRead(8'h0E, 32'h0, "R10");
    checkIdle(); // R11
    repeat (2) @(negedge clk);
    testCount++;
    if (expQ.size() != 0) begin
      failCount++;
      $display("FAIL R11 pending actual=%0d expected=0", expQ.size());
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule